// File: doc/BRIEF.md
# Four-Bit Universal Shift Register

This block holds a four-bit word and changes it on each rising clock edge according to a two-bit operation select. The four operations are HOLD (select 00, the word stays as it is), TO_D (select 01, every bit moves one stage toward the last stage and a serial bit enters the first stage), TO_A (select 10, every bit moves one stage toward the first stage and a second serial bit enters the last stage) and LOAD (select 11, the word is replaced by the parallel input). The stages are called A (index 0) through D (index 3). An active-low clear forces the word to zero at once and takes precedence over everything else.

The operation select is decoded every cycle into a named operation, and the stored word moves between values only along the four named transitions: HOLD keeps it, TO_D and TO_A shift it, LOAD replaces it. Clear assertion is a fifth, asynchronous transition to the all-zero word from any value. The block is meant as a storage, serialising and deserialising element inside larger datapaths: load a word and shift it out, shift a word in and read it in parallel, or park a value.

Top module: `ushreg_top`

## Requirements
- R1: While clr_n is 0, q_out is 4'b0000 at once, whatever the clock, op_sel, serial and parallel inputs, including across rising clock edges.
- R2: With op_sel = 2'b11 (LOAD), a rising edge copies par_in into q_out bit for bit (par_in[0] to stage A at q_out[0], par_in[3] to stage D at q_out[3]).
- R3: With op_sel = 2'b01 (TO_D), a rising edge puts fill_a in q_out[0] and the old q_out[i-1] in q_out[i] for i = 1..3.
- R4: With op_sel = 2'b10 (TO_A), a rising edge puts fill_d in q_out[3] and the old q_out[i+1] in q_out[i] for i = 0..2.
- R5: With op_sel = 2'b00 (HOLD), rising edges leave q_out unchanged whatever the serial and parallel inputs.
- R6: Without a rising edge and with clr_n at 1, q_out keeps its value in every operation; a falling clock edge and input changes have no effect.
- R7: After clr_n returns to 1, the first rising edge applies the operation then selected to the all-zero word.
- R8: In TO_D and TO_A the parallel input and the other direction's serial input have no effect; in LOAD both serial inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edge updates the word |
| clr_n | input | 1 | Asynchronous clear, active low |
| op_sel | input | 2 | Operation: 00 HOLD, 01 TO_D, 10 TO_A, 11 LOAD |
| fill_a | input | 1 | Serial bit entering stage A during TO_D |
| fill_d | input | 1 | Serial bit entering stage D during TO_A |
| par_in | input | 4 | Parallel word for LOAD, bit 0 is stage A |
| q_out | output | 4 | Stored word, bit 0 is stage A, bit 3 is stage D |

## Verification
The hardest situation to reach is clear arriving in the middle of an operation: the word must already hold a non-zero value that the operation is busy changing, and clear must fall between edges and stay low across a rising edge. The stimulus loads a known word, starts each of the four operations, drops clr_n mid-cycle, clocks with clear held low and then releases it under the same operation so the first edge after release is checked too. Around that, every starting word is combined with every operation, both values of both serial bits and a spread of parallel words, with the expected word computed by shifts and masks.

// File: rtl/ushreg_pkg.sv
package ushreg_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'b00,
        OP_TO_D = 2'b01,
        OP_TO_A = 2'b10,
        OP_LOAD = 2'b11
    } shift_op_e;

endpackage

// File: rtl/ushreg_op_decode.sv
module ushreg_op_decode
    import ushreg_pkg::*;
(
    input  logic [1:0] sel,
    output shift_op_e  op
);

    always_comb begin
        unique case (sel)
            2'b00:   op = OP_HOLD;
            2'b01:   op = OP_TO_D;
            2'b10:   op = OP_TO_A;
            default: op = OP_LOAD;
        endcase
    end

endmodule

// File: rtl/ushreg_next_mux.sv
module ushreg_next_mux
    import ushreg_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  shift_op_e        op,
    input  logic [WIDTH-1:0] cur,
    input  logic             fill_a,
    input  logic             fill_d,
    input  logic [WIDTH-1:0] par,
    output logic [WIDTH-1:0] nxt
);

    localparam int TOP_IDX = WIDTH - 1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        logic from_lower;
        logic from_upper;

        if (i == 0) begin : g_first
            assign from_lower = fill_a;
        end else begin : g_mid_lo
            assign from_lower = cur[i-1];
        end

        if (i == TOP_IDX) begin : g_last
            assign from_upper = fill_d;
        end else begin : g_mid_hi
            assign from_upper = cur[i+1];
        end

        always_comb begin
            unique case (op)
                OP_HOLD: nxt[i] = cur[i];
                OP_TO_D: nxt[i] = from_lower;
                OP_TO_A: nxt[i] = from_upper;
                OP_LOAD: nxt[i] = par[i];
                default: nxt[i] = cur[i];
            endcase
        end
    end

endmodule

// File: rtl/ushreg_bank.sv
module ushreg_bank #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] nxt,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            q <= '0;
        end else begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/ushreg_top.sv
module ushreg_top
    import ushreg_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [1:0]       op_sel,
    input  logic             fill_a,
    input  logic             fill_d,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] q_out
);

    shift_op_e        op;
    logic [WIDTH-1:0] word_q;
    logic [WIDTH-1:0] word_nxt;

    ushreg_op_decode u_dec (
        .sel (op_sel),
        .op  (op)
    );

    ushreg_next_mux #(.WIDTH(WIDTH)) u_mux (
        .op     (op),
        .cur    (word_q),
        .fill_a (fill_a),
        .fill_d (fill_d),
        .par    (par_in),
        .nxt    (word_nxt)
    );

    ushreg_bank #(.WIDTH(WIDTH)) u_bank (
        .clk   (clk),
        .clr_n (clr_n),
        .nxt   (word_nxt),
        .q     (word_q)
    );

    assign q_out = word_q;

endmodule

// File: rtl/ushreg_checker.sv
module ushreg_checker #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             clr_n,
    input logic [1:0]       op_sel,
    input logic             fill_a,
    input logic             fill_d,
    input logic [WIDTH-1:0] par_in,
    input logic [WIDTH-1:0] q_out
);

    // R1: an edge seen while clear is held low finds the word at zero
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            a_r1_clear_zero: assert (q_out == '0);
        end
    end

    // R2
    a_r2_load_copies: assert property (@(posedge clk) disable iff (!clr_n)
        (op_sel == 2'b11) |=> (q_out == $past(par_in)));

    // R3
    a_r3_shift_to_d: assert property (@(posedge clk) disable iff (!clr_n)
        (op_sel == 2'b01) |=> (q_out == {$past(q_out[WIDTH-2:0]), $past(fill_a)}));

    // R4
    a_r4_shift_to_a: assert property (@(posedge clk) disable iff (!clr_n)
        (op_sel == 2'b10) |=> (q_out == {$past(fill_d), $past(q_out[WIDTH-1:1])}));

    // R5
    a_r5_hold_stable: assert property (@(posedge clk) disable iff (!clr_n)
        (op_sel == 2'b00) |=> $stable(q_out));

endmodule

bind ushreg_top ushreg_checker #(.WIDTH(WIDTH)) u_chk (
    .clk    (clk),
    .clr_n  (clr_n),
    .op_sel (op_sel),
    .fill_a (fill_a),
    .fill_d (fill_d),
    .par_in (par_in),
    .q_out  (q_out)
);

// File: tb/tb_ushreg_top.sv
module tb_ushreg_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 200000;

    logic       clk = 1'b0;
    logic       clr_n = 1'b1;
    logic [1:0] op_sel = 2'b00;
    logic       fill_a = 1'b0;
    logic       fill_d = 1'b0;
    logic [3:0] par_in = 4'b0000;
    logic [3:0] q_out;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [3:0] exp_q;

    ushreg_top #(.WIDTH(4)) dut (
        .clk    (clk),
        .clr_n  (clr_n),
        .op_sel (op_sel),
        .fill_a (fill_a),
        .fill_d (fill_d),
        .par_in (par_in),
        .q_out  (q_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [3:0] model(input logic [1:0] m, input logic [3:0] s,
                                         input logic fa, input logic fd, input logic [3:0] p);
        case (m)
            2'b01:   return 4'((s << 1) | 4'(fa));
            2'b10:   return 4'((s >> 1) | (4'(fd) << 3));
            2'b11:   return p;
            default: return s;
        endcase
    endfunction

    function automatic string tag_of(input logic [1:0] m);
        case (m)
            2'b01:   return "R3 R8 shift to D";
            2'b10:   return "R4 R8 shift to A";
            2'b11:   return "R2 R8 load";
            default: return "R5 hold";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [3:0] expv);
        checks++;
        if (q_out !== expv) begin
            fails++;
            $display("FAIL %s: q_out=%b expected %b", tag, q_out, expv);
        end
    endtask

    // drive at the falling edge, check nothing moved, then check after the rising edge
    task automatic tick(input logic [1:0] m, input logic fa, input logic fd, input logic [3:0] p);
        @(negedge clk);
        op_sel = m; fill_a = fa; fill_d = fd; par_in = p;
        #1;
        chk("R6 no change off rising edge", exp_q);
        exp_q = model(m, exp_q, fa, fd, p);
        @(posedge clk);
        #1;
        chk(tag_of(m), exp_q);
    endtask

    task automatic clear_mid(input logic [1:0] m);
        tick(2'b11, 1'b0, 1'b0, 4'b1011);
        @(negedge clk);
        op_sel = m; fill_a = 1'b1; fill_d = 1'b1; par_in = 4'b0110;
        exp_q = model(m, exp_q, 1'b1, 1'b1, 4'b0110);
        @(posedge clk);
        #2;
        chk(tag_of(m), exp_q);
        clr_n = 1'b0;
        #1;
        exp_q = 4'b0000;
        chk("R1 clear mid operation", exp_q);
        @(posedge clk);
        #1;
        chk("R1 clear held across rising edge", exp_q);
        @(negedge clk);
        clr_n = 1'b1;
        #1;
        chk("R6 release without edge", exp_q);
        exp_q = model(m, 4'b0000, 1'b1, 1'b1, 4'b0110);
        @(posedge clk);
        #1;
        chk("R7 first edge after release", exp_q);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not end, actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : stim
        #1;
        clr_n = 1'b0;
        #1;
        exp_q = 4'b0000;
        chk("R1 reset state", exp_q);
        @(posedge clk);
        #1;
        chk("R1 rising edge during clear", exp_q);
        @(negedge clk);
        op_sel = 2'b11; par_in = 4'b1001;
        clr_n = 1'b1;
        exp_q = 4'b1001;
        @(posedge clk);
        #1;
        chk("R7 load after release", exp_q);

        // sweep: every start word, operation, serial pair and a spread of parallel words
        for (int s = 0; s < 16; s++) begin
            for (int m = 0; m < 4; m++) begin
                for (int f = 0; f < 4; f++) begin
                    for (int p = 0; p < 16; p += 5) begin
                        tick(2'b11, f[0], f[1], 4'(s));
                        tick(2'(m), f[0], f[1], 4'(p));
                    end
                end
            end
        end

        // serial fill runs: shift a full word of ones then zeros in each direction
        tick(2'b11, 1'b0, 1'b0, 4'b0000);
        for (int k = 0; k < 4; k++) tick(2'b01, 1'b1, 1'b0, 4'b0000);
        chk("R3 ones filled from A", 4'b1111);
        for (int k = 0; k < 4; k++) tick(2'b10, 1'b1, 1'b0, 4'b1111);
        chk("R4 zeros filled at D", 4'b0000);
        for (int k = 0; k < 4; k++) tick(2'b10, 1'b0, 1'b1, 4'b0000);
        chk("R4 ones filled from D", 4'b1111);
        for (int k = 0; k < 4; k++) tick(2'b01, 1'b0, 1'b1, 4'b0000);
        chk("R3 zeros filled at A", 4'b0000);

        // hold across several edges with busy inputs
        tick(2'b11, 1'b0, 1'b0, 4'b1010);
        for (int k = 0; k < 4; k++) tick(2'b00, k[0], ~k[0], 4'(k * 3));
        chk("R5 hold over edges", 4'b1010);

        for (int m = 0; m < 4; m++) clear_mid(2'(m));

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule